// File: doc/BRIEF.md
# Test Pin Router with Divider Clock Bypass

This block chooses which internal node appears on a single test pin. A 3-bit test code picks the node, and eight settings are possible. The choices are the tail bit of the serial configuration shift register, a constant high, a constant low, the reference clock, the loop-counter output, the final output clock, and that final output divided by four. One code does more than choose a node. It moves the clock that feeds the loop counter and the output divider away from the oscillator clock and onto the serial clock. In that mode the output divider sends the serial clock to the main output, unchanged when the divider is set to divide by 1. The loop-counter output, which need not have a 50% duty cycle, appears on the test pin. This gives a slow clock path that can be driven from the board for debug.

The test code sits in a small latch. The latch loads only while the parallel-load strobe is high. While the strobe is low, the latch is held at the shift-register setting, so the pin stays quiet by default. The clock change for the dividers is free of glitches: the select moves only in a cycle where both candidate clocks are low. All clock-like inputs are level signals that the system clock `clk` samples, and `clk` runs much faster than any of them.

Top module: `tpin_select`

## Requirements
- R1: With effective code 000, `test_pin` equals `shift_tail`.
- R2: Code 001 drives `test_pin` to 1, and code 101 drives it to 0, whatever the other inputs are.
- R3: Code 010 drives `ref_clk` onto `test_pin`, code 011 drives `mcnt_in`, and code 100 drives `fout_in`.
- R4: Code 111 drives onto `test_pin` bit 1 of a 2-bit counter. The counter advances on each rising edge of `fout_in` that `clk` samples. Reset clears it, so the pin reads 0, 0, 1, 1, 0 after 0 to 4 rising edges.
- R5: Code 110 (bypass) drives `mcnt_in` onto `test_pin` and requests the serial clock. Once `clk_sel` is 1, `div_clk` follows `ser_clk`. While `clk_sel` is 0, `div_clk` follows `vco_clk`.
- R6: `clk_sel` changes only at a `clk` edge where both `vco_clk` and `ser_clk` were sampled low. It moves toward the request: 1 for bypass, 0 for any other code.
- R7: While `par_load` is low, the effective code is 000 and a `code_load` pulse has no effect. After `par_load` rises, the code stays 000 until a new load.
- R8: At a `clk` edge where `par_load` and `code_load` are both high, `code_in` is captured. Changes on `code_in` without `code_load` have no effect.
- R9: After reset, the code is 000, `clk_sel` is 0 and the divide-by-4 counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load | input | 1 | Parallel-load strobe; low holds the test code at 000 |
| code_load | input | 1 | Capture strobe for `code_in` |
| code_in | input | 3 | New test code |
| ref_clk | input | 1 | Reference clock level |
| vco_clk | input | 1 | Oscillator-side clock level |
| ser_clk | input | 1 | Serial interface clock level |
| mcnt_in | input | 1 | Loop-counter output |
| fout_in | input | 1 | Final output clock |
| shift_tail | input | 1 | Serial output of the configuration shift register |
| test_pin | output | 1 | Selected test node |
| div_clk | output | 1 | Clock feeding the loop counter and the output divider |
| clk_sel | output | 1 | 1 when the dividers run from `ser_clk` |

## Verification
The hardest case to reach from the ports is a bypass request that arrives while one of the two clocks is high. The bench enters bypass with `vco_clk` held high, then leaves it with `ser_clk` held high. In both cases it checks that `clk_sel` stays put over several cycles, then drops the held clock and sees the switch complete. The divide-by-4 path depends on history, so it is exercised after a fresh reset, with counted `fout_in` pulses.

// File: rtl/tpin_pkg.sv
package tpin_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    TC_SHIFT   = 3'b000,
    TC_HIGH    = 3'b001,
    TC_REF     = 3'b010,
    TC_MCNT    = 3'b011,
    TC_FOUT    = 3'b100,
    TC_LOW     = 3'b101,
    TC_BYPASS  = 3'b110,
    TC_QUARTER = 3'b111
  } tcode_e;

  // True when the code reroutes the divider clock to the serial clock.
  function automatic logic code_is_bypass(input logic [CODE_W-1:0] c);
    return c == TC_BYPASS;
  endfunction

  // Node selection for the test pin.
  function automatic logic pick_node(input logic [CODE_W-1:0] c,
                                     input logic tail,
                                     input logic refc,
                                     input logic mcnt,
                                     input logic fout,
                                     input logic quarter);
    logic r;
    case (tcode_e'(c))
      TC_SHIFT:   r = tail;
      TC_HIGH:    r = 1'b1;
      TC_REF:     r = refc;
      TC_MCNT:    r = mcnt;
      TC_FOUT:    r = fout;
      TC_LOW:     r = 1'b0;
      TC_BYPASS:  r = mcnt;
      TC_QUARTER: r = quarter;
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tpin_code_latch.sv
module tpin_code_latch
  import tpin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_load,
  input  logic              code_load,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_eff
);

  logic [CODE_W-1:0] code_q;
  logic              take_code;

  assign take_code = par_load && code_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         code_q <= TC_SHIFT;
    else if (!par_load) code_q <= TC_SHIFT;
    else if (take_code) code_q <= code_in;
  end

  // A low strobe overrides the stored code at once.
  assign code_eff = par_load ? code_q : TC_SHIFT;

  assert_par_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !par_load |=> (code_q == TC_SHIFT));

  assert_load_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_code |=> (code_q == $past(code_in)));

  assert_hold_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (par_load && !code_load) |=> $stable(code_q));

endmodule

// File: rtl/tpin_quarter_div.sv
module tpin_quarter_div #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  output logic quarter
);

  localparam int MSB = DIV_W - 1;

  logic             src_q;
  logic             src_rise;
  logic [DIV_W-1:0] cnt_q;

  assign src_rise = src && !src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      src_q <= src;
      if (src_rise) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign quarter = cnt_q[MSB];

  assert_quarter_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !src_rise |=> $stable(cnt_q));

endmodule

// File: rtl/tpin_clk_switch.sv
module tpin_clk_switch (
  input  logic clk,
  input  logic rst_n,
  input  logic want_alt,
  input  logic clk_pri,
  input  logic clk_alt,
  output logic sel_alt,
  output logic clk_out
);

  logic both_low;
  logic switch_ok;

  assign both_low  = !clk_pri && !clk_alt;
  assign switch_ok = both_low && (want_alt != sel_alt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_alt <= 1'b0;
    else if (switch_ok) sel_alt <= want_alt;
  end

  assign clk_out = sel_alt ? clk_alt : clk_pri;

  assert_switch_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_alt != $past(sel_alt)) |-> (!$past(clk_pri) && !$past(clk_alt)));

  assert_switch_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_alt != $past(sel_alt)) |-> (sel_alt == $past(want_alt)));

endmodule

// File: rtl/tpin_select.sv
module tpin_select
  import tpin_pkg::*;
#(
  parameter int QDIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_load,
  input  logic              code_load,
  input  logic [CODE_W-1:0] code_in,
  input  logic              ref_clk,
  input  logic              vco_clk,
  input  logic              ser_clk,
  input  logic              mcnt_in,
  input  logic              fout_in,
  input  logic              shift_tail,
  output logic              test_pin,
  output logic              div_clk,
  output logic              clk_sel
);

  logic [CODE_W-1:0] code_eff;
  logic              quarter;
  logic              want_bypass;

  tpin_code_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_load  (par_load),
    .code_load (code_load),
    .code_in   (code_in),
    .code_eff  (code_eff)
  );

  tpin_quarter_div #(.DIV_W(QDIV_W)) u_quarter (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (fout_in),
    .quarter (quarter)
  );

  assign want_bypass = code_is_bypass(code_eff);

  tpin_clk_switch u_switch (
    .clk      (clk),
    .rst_n    (rst_n),
    .want_alt (want_bypass),
    .clk_pri  (vco_clk),
    .clk_alt  (ser_clk),
    .sel_alt  (clk_sel),
    .clk_out  (div_clk)
  );

  assign test_pin = pick_node(code_eff, shift_tail, ref_clk, mcnt_in,
                              fout_in, quarter);

  assert_bypass_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |-> (div_clk == ser_clk));

  assert_normal_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_sel |-> (div_clk == vco_clk));

  assert_sel_needs_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel) |-> $past(want_bypass));

  assert_par_low_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !par_load |-> (test_pin == shift_tail));

endmodule

// File: tb/tpin_select_tb.sv
module tpin_select_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       par_load = 1'b0;
  logic       code_load = 1'b0;
  logic [2:0] code_in = 3'b000;
  logic       ref_clk = 1'b0, vco_clk = 1'b0, ser_clk = 1'b0;
  logic       mcnt_in = 1'b0, fout_in = 1'b0, shift_tail = 1'b0;
  logic       test_pin, div_clk, clk_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tpin_select u_dut (
    .clk(clk), .rst_n(rst_n), .par_load(par_load), .code_load(code_load),
    .code_in(code_in), .ref_clk(ref_clk), .vco_clk(vco_clk), .ser_clk(ser_clk),
    .mcnt_in(mcnt_in), .fout_in(fout_in), .shift_tail(shift_tail),
    .test_pin(test_pin), .div_clk(div_clk), .clk_sel(clk_sel)
  );

  // {code[2:0], shift_tail, ref_clk, mcnt_in, fout_in, expected pin}
  localparam int NV = 12;
  localparam logic [7:0] VECS [NV] = '{
    8'b000_1000_1, 8'b000_0111_0,
    8'b001_0000_1, 8'b101_1111_0,
    8'b010_0100_1, 8'b010_1011_0,
    8'b011_0010_1, 8'b011_1101_0,
    8'b100_0001_1, 8'b100_1110_0,
    8'b110_0010_1, 8'b110_1101_0
  };

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'b000:         return "R1";
      3'b001, 3'b101: return "R2";
      3'b110:         return "R5";
      default:        return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load_code(input logic [2:0] c);
    @(negedge clk);
    code_in = c;
    code_load = 1'b1;
    @(negedge clk);
    code_load = 1'b0;
  endtask

  task automatic fout_pulse();
    @(negedge clk); fout_in = 1'b1;
    @(negedge clk); fout_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    par_load = 1'b1;
    // R9 reset state
    shift_tail = 1'b1; #1;
    chk("R9", clk_sel, 1'b0);
    chk("R9", test_pin, 1'b1);
    vco_clk = 1'b1; #1;
    chk("R9", div_clk, 1'b1);
    vco_clk = 1'b0;

    // Table walk: R1, R2, R3, R5
    for (int i = 0; i < NV; i++) begin
      load_code(VECS[i][7:5]);
      shift_tail = VECS[i][4];
      ref_clk    = VECS[i][3];
      mcnt_in    = VECS[i][2];
      fout_in    = VECS[i][1];
      #1;
      chk(req_of(VECS[i][7:5]), test_pin, VECS[i][0]);
    end
    fout_in = 1'b0; ref_clk = 1'b0; mcnt_in = 1'b0;

    // R8: code_in moves without code_load -> still bypass code (pin=mcnt)
    @(negedge clk); code_in = 3'b001;
    repeat (2) @(negedge clk);
    mcnt_in = 1'b0; #1;
    chk("R8", test_pin, 1'b0);

    // Back to code 000 with both clocks low
    load_code(3'b000);
    @(negedge clk); #1;
    chk("R6", clk_sel, 1'b0);

    // R6: bypass requested while vco_clk high -> no switch
    vco_clk = 1'b1;
    load_code(3'b110);
    repeat (4) @(negedge clk); #1;
    chk("R6", clk_sel, 1'b0);
    chk("R5", div_clk, 1'b1);
    vco_clk = 1'b0;
    @(negedge clk); #1;
    chk("R6", clk_sel, 1'b1);
    ser_clk = 1'b1; #1;
    chk("R5", div_clk, 1'b1);
    ser_clk = 1'b0; #1;
    chk("R5", div_clk, 1'b0);

    // R7: par_load low with ser_clk high; select must hold until low
    ser_clk = 1'b1;
    par_load = 1'b0;
    shift_tail = 1'b0; mcnt_in = 1'b1; #1;
    chk("R7", test_pin, 1'b0);
    repeat (3) @(negedge clk); #1;
    chk("R6", clk_sel, 1'b1);
    ser_clk = 1'b0;
    @(negedge clk); #1;
    chk("R6", clk_sel, 1'b0);

    // R7: load ignored while par_load low
    load_code(3'b001);
    par_load = 1'b1;
    @(negedge clk);
    shift_tail = 1'b0; #1;
    chk("R7", test_pin, 1'b0);
    shift_tail = 1'b1; #1;
    chk("R7", test_pin, 1'b1);

    // R4: divide-by-4 after fresh reset
    do_reset();
    load_code(3'b111);
    #1; chk("R4", test_pin, 1'b0);
    fout_pulse(); #1; chk("R4", test_pin, 1'b0);
    fout_pulse(); #1; chk("R4", test_pin, 1'b1);
    fout_pulse(); #1; chk("R4", test_pin, 1'b1);
    fout_pulse(); #1; chk("R4", test_pin, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule